// File: doc/BRIEF.md
# Translation Buffer with Hardware Page-Table Refill

This block turns 32-bit virtual addresses into 30-bit physical addresses with 4 KiB pages. It keeps a small, fully associative set of recent translations. A requester presents an address and a write flag on the lookup port. On a hit the physical address comes back in the same cycle, together with the entry's stored status. On a miss the block starts a hardware walk and the requester presents the same address again once the port is ready.

The walker has four states. WK_IDLE accepts lookups. A lookup miss takes the transition IDLE->FETCH. WK_FETCH holds a memory read request until it is acknowledged. The acknowledge takes FETCH->INSTALL when the returned entry is valid and FETCH->FAULT when it is not. WK_INSTALL writes the new translation into the victim slot and WK_FAULT raises a one-cycle page-fault pulse. Both return to idle through INSTALL->IDLE or FAULT->IDLE.

Each slot holds a valid bit, the virtual page tag, the physical page, a write-permission bit, a dirty bit and a reference bit. Recency is kept as a per-slot age. A flush input drops every translation at once.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no translation is valid, `req_ready_o` is high, and `mem_req_o`, `rsp_hit_o` and `pgfault_o` are low.
- R2: A lookup that hits sets `rsp_hit_o` in the same cycle it is presented. `rsp_pa_o` is the stored physical page in bits 29..12, and bits 11..0 are copied from the virtual address.
- R3: A lookup that misses reports `rsp_hit_o` low. In the next cycle `mem_req_o` is high, with `mem_addr_o` equal to `ptbr_i` plus the virtual page number (bits 31..12), as a word address. The request and address are held until `mem_ack_i`, and `req_ready_o` stays low until the walk ends.
- R4: The page-table word uses bit 31 as valid, bit 30 as write permission and bits 17..0 as the physical page. A valid word is installed, and the next lookup of that page hits with that physical page.
- R5: A fetched word with bit 31 clear raises `pgfault_o` for exactly one cycle and installs nothing, so the next lookup of that page misses again.
- R6: A fill goes to the lowest-indexed invalid slot. When all slots are valid, it goes to the least recently used slot, where both hits and fills count as use.
- R7: `rsp_ref_o` reports the hit slot's reference bit as stored before the access. A fill clears the bit and any hit sets it.
- R8: `rsp_dirty_o` reports the hit slot's dirty bit as stored before the access. A fill clears the bit and a write hit with write permission sets it.
- R9: A write hit on a slot without write permission raises `rsp_prot_o` and leaves the dirty bit clear.
- R10: `flush_i` invalidates every slot in one edge, and `req_ready_o` is low while `flush_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all translations |
| ptbr_i | input | 32 | Page-table base, word address |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_ready_o | output | 1 | Lookup port can accept |
| rsp_hit_o | output | 1 | Translation found |
| rsp_pa_o | output | 30 | Physical address on hit |
| rsp_prot_o | output | 1 | Write to a read-only page |
| rsp_dirty_o | output | 1 | Stored dirty bit of hit slot |
| rsp_ref_o | output | 1 | Stored reference bit of hit slot |
| pgfault_o | output | 1 | One-cycle page-fault pulse |
| mem_req_o | output | 1 | Page-table read request |
| mem_addr_o | output | 32 | Page-table word address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Page-table word |

## Verification
The bench builds the block with its default of eight slots. Nine distinct pages are therefore enough to fill every slot and force a least-recently-used eviction. The bench's memory model answers each walk after a twelve-cycle latency, which keeps a walk in flight across many idle edges and tests the hold of the request and address. Its page table marks odd pages read-only and one page invalid. This lets protection faults and page faults occur within a short run.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 30;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int PTE_W     = 32;
    localparam int PTE_V_BIT = 31;
    localparam int PTE_W_BIT = 30;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;

    typedef struct packed {
        logic valid;
        logic wr_ok;
        logic dirty;
        logic refd;
        vpn_t tag;
        ppn_t ppn;
    } slot_t;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_FETCH,
        WK_INSTALL,
        WK_FAULT
    } wk_state_t;
endpackage

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en_i,
    input  logic [IDX_W-1:0]   touch_idx_i,
    input  logic [ENTRIES-1:0] valid_i,
    output logic [IDX_W-1:0]   victim_o
);
    logic [IDX_W-1:0] ages [ENTRIES];

    // ages form a permutation: touched slot goes to 0, younger ones age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ages[i] <= IDX_W'(i);
        end else if (touch_en_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx_i)
                    ages[i] <= '0;
                else if (ages[i] < ages[touch_idx_i])
                    ages[i] <= ages[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        victim_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !valid_i[i]) begin
                victim_o = IDX_W'(i);
                found    = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && ages[i] == IDX_W'(ENTRIES-1)) begin
                victim_o = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_slots.sv
module xlat_slots
    import xlat_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic lk_en_i,
    input  logic lk_write_i,
    input  vpn_t lk_vpn_i,
    output logic hit_o,
    output ppn_t hit_ppn_o,
    output logic hit_wr_o,
    output logic hit_dirty_o,
    output logic hit_ref_o,
    input  logic fill_en_i,
    input  vpn_t fill_vpn_i,
    input  ppn_t fill_ppn_i,
    input  logic fill_wr_i
);
    slot_t              slots [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   touch_idx;
    logic               touch_en;
    logic               do_fill;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g]     = slots[g].valid && (slots[g].tag == lk_vpn_i);
        assign valid_vec[g] = slots[g].valid;
    end

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (match[i]) hit_idx = IDX_W'(i);
    end

    assign hit_o       = |match;
    assign hit_ppn_o   = slots[hit_idx].ppn;
    assign hit_wr_o    = slots[hit_idx].wr_ok;
    assign hit_dirty_o = slots[hit_idx].dirty;
    assign hit_ref_o   = slots[hit_idx].refd;

    assign do_fill   = fill_en_i && !flush_i;
    assign touch_en  = do_fill || (lk_en_i && hit_o);
    assign touch_idx = do_fill ? victim_idx : hit_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
        end else if (flush_i) begin
            for (int i = 0; i < ENTRIES; i++) slots[i].valid <= 1'b0;
        end else if (fill_en_i) begin
            slots[victim_idx] <= '{valid: 1'b1, wr_ok: fill_wr_i, dirty: 1'b0,
                                   refd: 1'b0, tag: fill_vpn_i, ppn: fill_ppn_i};
        end else if (lk_en_i && hit_o) begin
            slots[hit_idx].refd <= 1'b1;
            if (lk_write_i && slots[hit_idx].wr_ok)
                slots[hit_idx].dirty <= 1'b1;
        end
    end

    xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_en_i  (touch_en),
        .touch_idx_i (touch_idx),
        .valid_i     (valid_vec),
        .victim_o    (victim_idx)
    );
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  vpn_t             start_vpn_i,
    input  logic [VA_W-1:0]  ptbr_i,
    output logic             mem_req_o,
    output logic [VA_W-1:0]  mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [PTE_W-1:0] mem_rdata_i,
    output logic             idle_o,
    output logic             fill_en_o,
    output vpn_t             fill_vpn_o,
    output ppn_t             fill_ppn_o,
    output logic             fill_wr_o,
    output logic             pgfault_o
);
    wk_state_t        state_q, state_d;
    vpn_t             vpn_q;
    logic [VA_W-1:0]  addr_q;
    ppn_t             ppn_q;
    logic             wr_q;
    logic             rsvd_unused;

    assign rsvd_unused = ^mem_rdata_i[PTE_W_BIT-1:PPN_W];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WK_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            addr_q <= '0;
            ppn_q  <= '0;
            wr_q   <= 1'b0;
        end else begin
            if (state_q == WK_IDLE && start_i) begin
                vpn_q  <= start_vpn_i;
                addr_q <= ptbr_i + VA_W'(start_vpn_i);
            end
            if (state_q == WK_FETCH && mem_ack_i) begin
                ppn_q <= mem_rdata_i[PPN_W-1:0];
                wr_q  <= mem_rdata_i[PTE_W_BIT];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE:    if (start_i) state_d = WK_FETCH;
            WK_FETCH:   if (mem_ack_i)
                            state_d = mem_rdata_i[PTE_V_BIT] ? WK_INSTALL : WK_FAULT;
            WK_INSTALL: state_d = WK_IDLE;
            WK_FAULT:   state_d = WK_IDLE;
            default:    state_d = WK_IDLE;
        endcase
    end

    always_comb begin
        mem_req_o = 1'b0;
        idle_o    = 1'b0;
        fill_en_o = 1'b0;
        pgfault_o = 1'b0;
        unique case (state_q)
            WK_IDLE:    idle_o    = 1'b1;
            WK_FETCH:   mem_req_o = 1'b1;
            WK_INSTALL: fill_en_o = 1'b1;
            WK_FAULT:   pgfault_o = 1'b1;
            default:    idle_o    = 1'b0;
        endcase
    end

    assign mem_addr_o = addr_q;
    assign fill_vpn_o = vpn_q;
    assign fill_ppn_o = ppn_q;
    assign fill_wr_o  = wr_q;
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [VA_W-1:0]  ptbr_i,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  req_va_i,
    input  logic             req_write_i,
    output logic             req_ready_o,
    output logic             rsp_hit_o,
    output logic [PA_W-1:0]  rsp_pa_o,
    output logic             rsp_prot_o,
    output logic             rsp_dirty_o,
    output logic             rsp_ref_o,
    output logic             pgfault_o,
    output logic             mem_req_o,
    output logic [VA_W-1:0]  mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [PTE_W-1:0] mem_rdata_i
);
    logic walk_idle, lk_en, slot_hit, hit_wr, hit_dirty, hit_ref;
    logic fill_en, fill_wr, walk_start;
    ppn_t hit_ppn, fill_ppn;
    vpn_t fill_vpn, req_vpn;

    assign req_vpn     = req_va_i[VA_W-1:OFF_W];
    assign req_ready_o = walk_idle && !flush_i;
    assign lk_en       = req_valid_i && req_ready_o;
    assign walk_start  = lk_en && !slot_hit;

    assign rsp_hit_o   = lk_en && slot_hit;
    assign rsp_pa_o    = rsp_hit_o ? {hit_ppn, req_va_i[OFF_W-1:0]} : '0;
    assign rsp_prot_o  = rsp_hit_o && req_write_i && !hit_wr;
    assign rsp_dirty_o = rsp_hit_o && hit_dirty;
    assign rsp_ref_o   = rsp_hit_o && hit_ref;

    xlat_slots #(.ENTRIES(ENTRIES)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .lk_en_i     (lk_en),
        .lk_write_i  (req_write_i),
        .lk_vpn_i    (req_vpn),
        .hit_o       (slot_hit),
        .hit_ppn_o   (hit_ppn),
        .hit_wr_o    (hit_wr),
        .hit_dirty_o (hit_dirty),
        .hit_ref_o   (hit_ref),
        .fill_en_i   (fill_en),
        .fill_vpn_i  (fill_vpn),
        .fill_ppn_i  (fill_ppn),
        .fill_wr_i   (fill_wr)
    );

    xlat_walker u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (walk_start),
        .start_vpn_i (req_vpn),
        .ptbr_i      (ptbr_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .idle_o      (walk_idle),
        .fill_en_o   (fill_en),
        .fill_vpn_o  (fill_vpn),
        .fill_ppn_o  (fill_ppn),
        .fill_wr_o   (fill_wr),
        .pgfault_o   (pgfault_o)
    );
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_i,
    input logic        req_valid_i,
    input logic [31:0] req_va_i,
    input logic        req_write_i,
    input logic        req_ready_o,
    input logic        rsp_hit_o,
    input logic [29:0] rsp_pa_o,
    input logic        rsp_prot_o,
    input logic        pgfault_o,
    input logic        mem_req_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_ack_i
);
    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> rsp_pa_o[11:0] == req_va_i[11:0]); // R2
    AST_MISS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o && !rsp_hit_o |=> mem_req_o); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R3
    AST_BUSY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o && !rsp_hit_o); // R3
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pgfault_o |=> !pgfault_o); // R5
    AST_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot_o |-> rsp_hit_o && req_write_i); // R9
    AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !req_ready_o); // R10
endmodule

bind xlat_buffer xlat_buffer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .req_valid_i (req_valid_i),
    .req_va_i    (req_va_i),
    .req_write_i (req_write_i),
    .req_ready_o (req_ready_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_pa_o    (rsp_pa_o),
    .rsp_prot_o  (rsp_prot_o),
    .pgfault_o   (pgfault_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i)
);

// File: tb/xlat_buffer_test.sv
module xlat_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 12;
    localparam logic [31:0] PT_BASE = 32'h0004_0000;
    localparam int NVEC = 8;
    // {va[31:0], wr, miss, pfault, prot, dirty_before, ref_before}
    localparam logic [37:0] VECS [NVEC] = '{
        {32'h0001_0123, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h0001_0FFC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {32'h0001_0004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {32'h0001_0800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {32'h0001_1010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {32'h0001_1020, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {32'h000F_F123, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {32'h0002_0ABC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_va_i = '0;
    logic        req_write_i = 1'b0;
    logic        req_ready_o, rsp_hit_o, rsp_prot_o, rsp_dirty_o, rsp_ref_o;
    logic [29:0] rsp_pa_o;
    logic        pgfault_o, mem_req_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_rdata_i;

    int checks = 0;
    int errors = 0;
    int pf_seen = 0;
    logic        s_hit, s_prot, s_dirty, s_ref, s_mreq;
    logic [29:0] s_pa;
    logic [31:0] s_maddr;

    xlat_buffer uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .ptbr_i(PT_BASE),
        .req_valid_i(req_valid_i), .req_va_i(req_va_i), .req_write_i(req_write_i),
        .req_ready_o(req_ready_o), .rsp_hit_o(rsp_hit_o), .rsp_pa_o(rsp_pa_o),
        .rsp_prot_o(rsp_prot_o), .rsp_dirty_o(rsp_dirty_o), .rsp_ref_o(rsp_ref_o),
        .pgfault_o(pgfault_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pte_of(input logic [19:0] vpn);
        logic [17:0] ppn;
        ppn = 18'(vpn * 3 + 5);
        return {vpn[7:0] != 8'hFF, !vpn[0], 12'h000, ppn};
    endfunction

    function automatic logic [29:0] pa_of(input logic [31:0] va);
        logic [31:0] p;
        p = pte_of(va[31:12]);
        return {p[17:0], va[11:0]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // page-table memory model
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        mem_ack_i = 1'b0;
        mem_rdata_i = '0;
        forever begin
            @(negedge clk);
            if (mem_req_o && !mem_ack_i) begin
                if (wait_cnt == MEM_LAT) begin
                    mem_ack_i = 1'b1;
                    mem_rdata_i = pte_of(20'(mem_addr_o - PT_BASE));
                    wait_cnt = 0;
                end else wait_cnt++;
            end else mem_ack_i = 1'b0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (pgfault_o) pf_seen++;
    end

    task automatic probe(input logic [31:0] va, input logic wr);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_va_i = va;
        req_write_i = wr;
        #(CLK_PERIOD/4);
        s_hit = rsp_hit_o; s_pa = rsp_pa_o; s_prot = rsp_prot_o;
        s_dirty = rsp_dirty_o; s_ref = rsp_ref_o;
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        s_mreq = mem_req_o;
        s_maddr = mem_addr_o;
    endtask

    task automatic wait_walk();
        while (!req_ready_o) @(negedge clk);
    endtask

    task automatic fill_page(input logic [31:0] va);
        probe(va, 1'b0);
        wait_walk();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready", req_ready_o, 1);
        check("R1 mem_req", mem_req_o, 0);
        check("R1 hit", rsp_hit_o, 0);
        check("R1 pgfault", pgfault_o, 0);
        rst_n = 1'b1;
        probe(32'h0001_0000, 1'b0);
        check("R1 empty after reset", s_hit, 0);
        wait_walk();

        // flush, then walk the vector table
        @(negedge clk); flush_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R10 ready low in flush", req_ready_o, 0);
        @(negedge clk); flush_i = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] va;
            logic wr;
            int pf0;
            va = VECS[k][37:6];
            wr = VECS[k][5];
            probe(va, wr);
            if (VECS[k][4]) begin
                check("R3 miss", s_hit, 0);
                check("R3 walk started", s_mreq, 1);
                check("R3 walk address", s_maddr, PT_BASE + {12'h0, va[31:12]});
                pf0 = pf_seen;
                wait_walk();
                if (VECS[k][3]) begin
                    check("R5 one fault pulse", pf_seen - pf0, 1);
                    continue;
                end
                check("R4 no fault", pf_seen - pf0, 0);
                probe(va, wr);
            end
            check("R2 hit", s_hit, 1);
            check("R2 pa", s_pa, pa_of(va));
            check("R9 prot", s_prot, VECS[k][2]);
            check("R8 dirty", s_dirty, VECS[k][1]);
            check("R7 ref", s_ref, VECS[k][0]);
        end

        // R5: faulting page was not installed
        probe(32'h000F_F000, 1'b0);
        check("R5 still misses", s_hit, 0);
        wait_walk();

        // R10: flush drops a cached page
        @(negedge clk); flush_i = 1'b1;
        @(negedge clk); flush_i = 1'b0;
        probe(32'h0001_0000, 1'b0);
        check("R10 miss after flush", s_hit, 0);
        wait_walk();

        // R6: LRU replacement with all slots full
        @(negedge clk); flush_i = 1'b1;
        @(negedge clk); flush_i = 1'b0;
        for (int p = 0; p < 8; p++) fill_page({20'h00100 + 20'(p), 12'h000});
        probe(32'h0010_0000, 1'b0);
        check("R6 first page hit", s_hit, 1);
        fill_page(32'h0010_8000);
        probe(32'h0010_8000, 1'b0);
        check("R6 new page hit", s_hit, 1);
        probe(32'h0010_0000, 1'b0);
        check("R6 recent page kept", s_hit, 1);
        probe(32'h0010_1000, 1'b0);
        check("R6 lru page evicted", s_hit, 0);
        wait_walk();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule